// File: doc/BRIEF.md
# Asynchronous SRAM Cycle Controller

This block sits between a simple clocked host port and an asynchronous static RAM. The host raises a one-cycle request that gives a direction, an address and, for a write, a data word. The controller then drives the RAM's active-low chip select, write strobe and output gate, the address bus and a shared tri-state data bus. Each phase is held for a whole number of clock cycles, and a parameter sets each count. The defaults suit a 70 ns part clocked at 250 MHz: 18 cycles of access, a 14-cycle write strobe, one cycle of address lead and two cycles of recovery.

In a write, chip select falls first and the write strobe falls later, so the strobe edge starts the write. The strobe rises while chip select is still low, so the strobe edge also ends the write. The controller drives write data from the strobe's falling edge until one clock after its rising edge, and keeps the output gate inactive for the whole cycle. In a read, chip select and the output gate stay low together for the access count. The data bus is sampled on the last clock of that count. A one-cycle completion pulse closes every access, and a recovery interval follows before the controller takes a new request.

Top module: `sram_seq_ctrl`

## Requirements
- R1: While reset is held, chip select, write strobe and output gate are all high (inactive) and the completion pulse is low.
- R2: A read holds chip select low and output gate low, with the write strobe high, for exactly T_ACC cycles. The data bus value present on the last of those cycles appears on the read data output.
- R3: In a write, chip select falls T_AS cycles before the write strobe falls. The strobe stays low for exactly T_WP cycles and rises while chip select is still low. Chip select rises one cycle after the strobe, so chip select is low for T_AS+T_WP+1 cycles in total.
- R4: The output gate stays high on every cycle in which the write strobe is low.
- R5: The controller drives the data bus on every cycle in which the write strobe is low and on the one cycle after it rises. It never drives the bus while the output gate is low.
- R6: The address bus does not change while chip select stays low.
- R7: The driven write data equals the host's write word and stays constant for as long as it is driven.
- R8: A request is taken only in the idle state. After chip select rises it stays high for at least T_REC+1 cycles. A request raised during an access or during recovery starts no memory cycle and changes no memory word.
- R9: The completion pulse lasts exactly one cycle per access. It rises on the same clock edge on which chip select returns high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| req | input | 1 | One-cycle access request |
| wr | input | 1 | Direction of the request: 1 write, 0 read |
| addr | input | ADDR_W | Word address of the request |
| wdata | input | DATA_W | Write word |
| rdata | output | DATA_W | Word captured by the last read |
| done | output | 1 | One-cycle completion pulse |
| mem_ce_n | output | 1 | RAM chip select, active low |
| mem_we_n | output | 1 | RAM write strobe, active low |
| mem_oe_n | output | 1 | RAM output gate, active low |
| mem_addr | output | ADDR_W | RAM address bus |
| mem_dq | inout | DATA_W | RAM data bus, tri-state |

## Verification
Two events can fall on the same clock edge. A host request can arrive on the very edge at which a running access is in its read or write phase, or has just moved into recovery. Also, the completion pulse and the return of chip select are meant to share one edge. The bench provokes the first case by pulsing a conflicting write request in the middle of a read and again on the first recovery cycle. It then judges the result at the pins: the number of chip-select falls must equal the number of accepted requests, and a later read of the targeted word must return its old value. The bench judges the second case on every access by requiring the completion pulse on exactly the cycles where chip select has just risen.

// File: rtl/sram_seq_pkg.sv
package sram_seq_pkg;

  typedef enum logic [2:0] {
    ST_IDLE   = 3'd0,
    ST_LEAD   = 3'd1,
    ST_STROBE = 3'd2,
    ST_TAIL   = 3'd3,
    ST_FETCH  = 3'd4,
    ST_REST   = 3'd5
  } seq_state_t;

  function automatic int unsigned max4(input int unsigned a, input int unsigned b,
                                       input int unsigned c, input int unsigned d);
    int unsigned m;
    m = a;
    if (b > m) m = b;
    if (c > m) m = c;
    if (d > m) m = d;
    return m;
  endfunction

  function automatic logic holds_select(input seq_state_t s);
    return (s == ST_LEAD) || (s == ST_STROBE) || (s == ST_TAIL) || (s == ST_FETCH);
  endfunction

  function automatic logic drives_bus(input seq_state_t s);
    return (s == ST_STROBE) || (s == ST_TAIL);
  endfunction

endpackage

// File: rtl/sram_reset_sync.sv
module sram_reset_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  output logic rst_n_sync
);

  logic [STAGES-1:0] chain_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) chain_q <= '0;
    else        chain_q <= {chain_q[STAGES-2:0], 1'b1};
  end

  assign rst_n_sync = chain_q[STAGES-1];

endmodule

// File: rtl/sram_interval_timer.sv
module sram_interval_timer #(
  parameter int CNT_W = 5
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             load,
  input  logic [CNT_W-1:0] load_val,
  output logic             last
);

  logic [CNT_W-1:0] cnt_q;
  logic [CNT_W-1:0] cnt_d;
  logic             cnt_en;

  always_comb begin
    cnt_d  = cnt_q;
    cnt_en = 1'b0;
    if (load) begin
      cnt_d  = load_val;
      cnt_en = 1'b1;
    end else if (cnt_q != '0) begin
      cnt_d  = cnt_q - 1'b1;
      cnt_en = 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      cnt_q <= '0;
    else if (cnt_en) cnt_q <= cnt_d;
  end

  assign last = (cnt_q == '0);

endmodule

// File: rtl/sram_seq_fsm.sv
module sram_seq_fsm
  import sram_seq_pkg::*;
#(
  parameter int T_AS  = 1,
  parameter int T_WP  = 14,
  parameter int T_ACC = 18,
  parameter int T_REC = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic req,
  input  logic wr,
  output logic accept,
  output logic capture,
  output logic ce_n,
  output logic we_n,
  output logic oe_n,
  output logic drv_en,
  output logic done
);

  localparam int unsigned MAX_T = max4(T_AS, T_WP, T_ACC, T_REC);
  localparam int          CNT_W = $clog2(MAX_T) + 1;

  seq_state_t       state_q, state_d;
  logic             tmr_load, tmr_last;
  logic [CNT_W-1:0] tmr_val;
  logic             ce_n_d, we_n_d, oe_n_d, drv_d, done_d;

  sram_interval_timer #(.CNT_W(CNT_W)) u_timer (
    .clk      (clk),
    .rst_n    (rst_n),
    .load     (tmr_load),
    .load_val (tmr_val),
    .last     (tmr_last)
  );

  assign accept  = (state_q == ST_IDLE) && req;
  assign capture = (state_q == ST_FETCH) && tmr_last;

  always_comb begin
    state_d = state_q;
    unique case (state_q)
      ST_IDLE:   if (req) state_d = wr ? ST_LEAD : ST_FETCH;
      ST_LEAD:   if (tmr_last) state_d = ST_STROBE;
      ST_STROBE: if (tmr_last) state_d = ST_TAIL;
      ST_TAIL:   state_d = ST_REST;
      ST_FETCH:  if (tmr_last) state_d = ST_REST;
      ST_REST:   if (tmr_last) state_d = ST_IDLE;
      default:   state_d = ST_IDLE;
    endcase
  end

  always_comb begin
    tmr_load = (state_d != state_q);
    tmr_val  = '0;
    unique case (state_d)
      ST_LEAD:   tmr_val = CNT_W'(T_AS - 1);
      ST_STROBE: tmr_val = CNT_W'(T_WP - 1);
      ST_FETCH:  tmr_val = CNT_W'(T_ACC - 1);
      ST_REST:   tmr_val = CNT_W'(T_REC - 1);
      default:   tmr_val = '0;
    endcase
  end

  always_comb begin
    ce_n_d = ~holds_select(state_d);
    we_n_d = (state_d != ST_STROBE);
    oe_n_d = (state_d != ST_FETCH);
    drv_d  = drives_bus(state_d);
    done_d = (state_q == ST_TAIL) || capture;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= ST_IDLE;
      ce_n    <= 1'b1;
      we_n    <= 1'b1;
      oe_n    <= 1'b1;
      drv_en  <= 1'b0;
      done    <= 1'b0;
    end else begin
      state_q <= state_d;
      ce_n    <= ce_n_d;
      we_n    <= we_n_d;
      oe_n    <= oe_n_d;
      drv_en  <= drv_d;
      done    <= done_d;
    end
  end

  AST_GATE_OFF_IN_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
    !we_n |-> oe_n) else $error("gate low during strobe"); // R4
  AST_STROBE_INSIDE_SELECT: assert property (@(posedge clk) disable iff (!rst_n)
    !we_n |-> !ce_n) else $error("strobe outside select"); // R3
  AST_STROBE_FALLS_LATER: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(we_n) |-> $past(!ce_n)) else $error("strobe not the later fall"); // R3
  AST_STROBE_RISES_FIRST: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(ce_n) |-> $past(we_n)) else $error("select rose before strobe"); // R3
  AST_NO_DRIVE_WHILE_GATED: assert property (@(posedge clk) disable iff (!rst_n)
    drv_en |-> oe_n) else $error("bus driven into open gate"); // R5
  AST_DRIVE_UNDER_STROBE: assert property (@(posedge clk) disable iff (!rst_n)
    !we_n |-> drv_en) else $error("bus idle under strobe"); // R5
  AST_DRIVE_ONE_AFTER_RISE: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(we_n) |-> drv_en) else $error("no hold cycle"); // R5
  AST_DONE_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done) else $error("done longer than one cycle"); // R9
  AST_DONE_WITH_SELECT_RISE: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> $rose(ce_n)) else $error("done off select rise"); // R9
  AST_ACCEPT_ONLY_RELEASED: assert property (@(posedge clk) disable iff (!rst_n)
    accept |-> ce_n && we_n && oe_n) else $error("accept while busy"); // R8

endmodule

// File: rtl/sram_data_path.sv
module sram_data_path #(
  parameter int ADDR_W = 20,
  parameter int DATA_W = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              accept,
  input  logic              capture,
  input  logic              ce_n,
  input  logic              drv_en,
  input  logic [ADDR_W-1:0] addr,
  input  logic [DATA_W-1:0] wdata,
  input  logic [DATA_W-1:0] bus_in,
  output logic [ADDR_W-1:0] mem_addr,
  output logic [DATA_W-1:0] bus_out,
  output logic [DATA_W-1:0] rdata
);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mem_addr <= '0;
      bus_out  <= '0;
    end else if (accept) begin
      mem_addr <= addr;
      bus_out  <= wdata;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       rdata <= '0;
    else if (capture) rdata <= bus_in;
  end

  AST_ADDR_HELD: assert property (@(posedge clk) disable iff (!rst_n)
    (!ce_n && $past(!ce_n)) |-> $stable(mem_addr)) else $error("address moved"); // R6
  AST_WDATA_HELD: assert property (@(posedge clk) disable iff (!rst_n)
    (drv_en && $past(drv_en)) |-> $stable(bus_out)) else $error("write data moved"); // R7

endmodule

// File: rtl/sram_seq_ctrl.sv
module sram_seq_ctrl #(
  parameter int ADDR_W = 20,
  parameter int DATA_W = 32,
  parameter int T_AS   = 1,
  parameter int T_WP   = 14,
  parameter int T_ACC  = 18,
  parameter int T_REC  = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req,
  input  logic              wr,
  input  logic [ADDR_W-1:0] addr,
  input  logic [DATA_W-1:0] wdata,
  output logic [DATA_W-1:0] rdata,
  output logic              done,
  output logic              mem_ce_n,
  output logic              mem_we_n,
  output logic              mem_oe_n,
  output logic [ADDR_W-1:0] mem_addr,
  inout  wire  [DATA_W-1:0] mem_dq
);

  logic              rst_n_s;
  logic              accept, capture, drv_en;
  logic [DATA_W-1:0] bus_out;

  sram_reset_sync #(.STAGES(2)) u_rst (
    .clk        (clk),
    .rst_n      (rst_n),
    .rst_n_sync (rst_n_s)
  );

  sram_seq_fsm #(
    .T_AS (T_AS),
    .T_WP (T_WP),
    .T_ACC(T_ACC),
    .T_REC(T_REC)
  ) u_fsm (
    .clk     (clk),
    .rst_n   (rst_n_s),
    .req     (req),
    .wr      (wr),
    .accept  (accept),
    .capture (capture),
    .ce_n    (mem_ce_n),
    .we_n    (mem_we_n),
    .oe_n    (mem_oe_n),
    .drv_en  (drv_en),
    .done    (done)
  );

  sram_data_path #(
    .ADDR_W(ADDR_W),
    .DATA_W(DATA_W)
  ) u_dp (
    .clk      (clk),
    .rst_n    (rst_n_s),
    .accept   (accept),
    .capture  (capture),
    .ce_n     (mem_ce_n),
    .drv_en   (drv_en),
    .addr     (addr),
    .wdata    (wdata),
    .bus_in   (mem_dq),
    .mem_addr (mem_addr),
    .bus_out  (bus_out),
    .rdata    (rdata)
  );

  assign mem_dq = drv_en ? bus_out : {DATA_W{1'bz}};

endmodule

// File: tb/sim_sram_seq_ctrl.sv
module sim_sram_seq_ctrl;

  localparam int AW = 4;
  localparam int DW = 16;
  localparam int T_AS = 1;
  localparam int T_WP = 14;
  localparam int T_ACC = 18;
  localparam int T_REC = 2;
  localparam int WORDS = 1 << AW;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          req = 1'b0;
  logic          wr = 1'b0;
  logic [AW-1:0] addr = '0;
  logic [DW-1:0] wdata = '0;
  logic [DW-1:0] rdata;
  logic          done, ce_n, we_n, oe_n;
  logic [AW-1:0] maddr;
  wire  [DW-1:0] dq;

  int checks = 0;
  int fails = 0;

  logic [DW-1:0] mem [WORDS];
  logic [DW-1:0] expv [WORDS];
  logic          model_drv;
  logic [DW-1:0] model_val;
  int            rd_cnt = 0;

  always #2 clk = ~clk;

  sram_seq_ctrl #(.ADDR_W(AW), .DATA_W(DW), .T_AS(T_AS), .T_WP(T_WP),
                  .T_ACC(T_ACC), .T_REC(T_REC)) u0 (
    .clk(clk), .rst_n(rst_n), .req(req), .wr(wr), .addr(addr), .wdata(wdata),
    .rdata(rdata), .done(done), .mem_ce_n(ce_n), .mem_we_n(we_n),
    .mem_oe_n(oe_n), .mem_addr(maddr), .mem_dq(dq));

  assign model_drv = !ce_n && !oe_n && we_n;
  assign model_val = (rd_cnt >= T_ACC) ? mem[maddr] : ~mem[maddr];
  assign dq = model_drv ? model_val : {DW{1'bz}};

  task automatic chk(input logic ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  // pin monitor and memory model, sampled on the falling edge
  logic          ce_p = 1'b1, we_p = 1'b1, done_p = 1'b0;
  int            ce_lo = 0, we_lo = 0, ce_hi = 0;
  int            falls = 0, accepted = 0;
  logic          addr_bad = 1'b0, data_bad = 1'b0, was_write = 1'b0, armed = 1'b0;
  logic [AW-1:0] addr_p = '0;
  logic [DW-1:0] cur_w = '0;

  always @(negedge clk) begin
    if (rst_n && armed) begin
      rd_cnt = model_drv ? rd_cnt + 1 : 0;
      if (ce_p && !ce_n) begin
        falls++;
        if (falls > 1) chk(ce_hi >= T_REC + 1, "R8 select high gap", ce_hi, T_REC + 1);
        ce_lo = 0; addr_bad = 1'b0; data_bad = 1'b0; was_write = 1'b0;
      end
      if (!ce_n && !ce_p && maddr != addr_p) addr_bad = 1'b1;
      if (we_p && !we_n) begin
        was_write = 1'b1;
        chk(ce_lo == T_AS, "R3 lead before strobe", ce_lo, T_AS);
        we_lo = 0;
      end
      if (!we_n && dq !== cur_w) data_bad = 1'b1;
      if (!we_p && we_n) begin
        chk(!ce_n, "R3 strobe rises under select", ce_n, 0);
        chk(we_lo == T_WP, "R3 strobe width", we_lo, T_WP);
        chk(!data_bad && dq === cur_w, "R7 R5 driven write data", dq, cur_w);
        if (!ce_n) mem[maddr] = dq;
      end
      if (!ce_p && ce_n) begin
        if (was_write) chk(ce_lo == T_AS + T_WP + 1, "R3 select width", ce_lo, T_AS + T_WP + 1);
        else chk(ce_lo == T_ACC, "R2 read select width", ce_lo, T_ACC);
        chk(!addr_bad, "R6 address held", addr_bad, 0);
        ce_hi = 0;
      end
      if (done != (!ce_p && ce_n) || (done && done_p))
        chk(1'b0, "R9 done pulse", done, !ce_p && ce_n);
      if (!ce_n) ce_lo++; else ce_hi++;
      if (!we_n) we_lo++;
      if (!ce_n) addr_p = maddr;
      ce_p = ce_n; we_p = we_n; done_p = done;
    end
  end

  task automatic summary();
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    chk(1'b0, "watchdog", 0, 1);
    summary();
  end

  task automatic access(input logic w, input logic [AW-1:0] a, input logic [DW-1:0] d);
    int n;
    @(negedge clk);
    req = 1'b1; wr = w; addr = a; wdata = d;
    if (w) cur_w = d;
    accepted++;
    @(negedge clk);
    req = 1'b0;
    n = 0;
    while (!done && n < 1000) begin
      @(negedge clk);
      n++;
    end
    chk(done, "R9 completion seen", done, 1);
    if (w) expv[a] = d;
    else chk(rdata == expv[a], "R2 read word", rdata, expv[a]);
    repeat (T_REC - 1) @(negedge clk);
  endtask

  function automatic logic [DW-1:0] pat(input int a, input int k);
    return DW'(a * 16'h1357) ^ DW'(k * 16'h5A5A) ^ 16'hA5C3;
  endfunction

  initial begin
    for (int i = 0; i < WORDS; i++) begin mem[i] = '0; expv[i] = '0; end
    repeat (3) @(negedge clk);
    chk(ce_n && we_n && oe_n, "R1 pins idle in reset", {ce_n, we_n, oe_n}, 3'b111);
    chk(!done, "R1 done low in reset", done, 0);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    armed = 1'b1;
    chk(ce_n && we_n && oe_n && !done, "R1 idle after reset", {ce_n, we_n, oe_n, done}, 4'b1110);
    for (int k = 0; k < 2; k++) begin
      for (int a = 0; a < WORDS; a++) access(1'b1, AW'(k == 0 ? a : WORDS - 1 - a), pat(a, k));
      for (int a = 0; a < WORDS; a++) access(1'b0, AW'(a), '0);
    end
    // R8: request during a read is ignored
    @(negedge clk);
    req = 1'b1; wr = 1'b0; addr = 4'd5; accepted++;
    @(negedge clk);
    req = 1'b0;
    repeat (5) @(negedge clk);
    req = 1'b1; wr = 1'b1; addr = 4'd3; wdata = 16'hFFFF;
    @(negedge clk);
    req = 1'b0;
    while (!done) @(negedge clk);
    chk(rdata == expv[5], "R2 read under conflict", rdata, expv[5]);
    // R8: request on first recovery cycle is ignored
    req = 1'b1; wr = 1'b1; addr = 4'd3; wdata = 16'hFFFF;
    @(negedge clk);
    req = 1'b0;
    repeat (T_REC + 3) @(negedge clk);
    chk(falls == accepted, "R8 no extra memory cycle", falls, accepted);
    access(1'b0, 4'd3, '0);
    chk(rdata == expv[3], "R8 ignored write left word", rdata, expv[3]);
    access(1'b1, 4'd0, 16'h0000);
    access(1'b1, 4'd15, 16'hFFFF);
    access(1'b0, 4'd0, '0);
    access(1'b0, 4'd15, '0);
    chk(falls == accepted, "R8 cycle count", falls, accepted);
    summary();
  end

endmodule